// File: doc/BRIEF.md
# Windowed Bus Address Translator

This block sits between a local bus and a point-to-point serial link and converts addresses in both directions. On the outbound side, an access that falls inside the fixed 64 MB local window reserved for the remote device is moved onto the remote address space. The window runs from 4C00_0000h to 4FFF_FFFFh. The move replaces the window base with a programmable remote base and keeps the offset within the window. Accesses outside the window are not forwarded.

On the inbound side, an address arriving from the link is decoded against four regions placed back to back from address zero. Each region has a programmable length and a relocation offset. A matching address becomes its distance from the start of its region plus that region's offset. An address that matches no region raises no hit. A small register port holds the outbound base and the four length/offset pairs.

Top module: `addr_xlat`

## Requirements
- R1: After reset, every map register reads as zero, and an in-window outbound access translates onto base zero.
- R2: A register write stores bits [31:2] of the write data, and bits [1:0] always read as zero. Register index 0 is the outbound base. Index 1+2n is the length of region n and index 2+2n is its offset, for n = 0..3. `reg_rdata` shows the register selected by `reg_addr` one cycle after `reg_addr` is applied.
- R3: Indices 9 to 15 read as zero, and writes to them change no register.
- R4: An outbound address in 4C00_0000h..4FFF_FFFFh produces `tx_out_valid` one cycle later, with `tx_out_addr` = base + (address − 4C00_0000h), modulo 2^32.
- R5: An outbound address below 4C00_0000h or above 4FFF_FFFFh, or any cycle with `tx_in_valid` low, gives `tx_out_valid` low and `tx_out_addr` zero one cycle later.
- R6: Inbound region n covers [L0+…+L(n−1), L0+…+Ln), where Lk is the length of region k. The lower bound is inclusive and the upper bound exclusive.
- R7: A hit on region n gives `rx_out_addr` = address − start of region n + offset n, one cycle after the input.
- R8: An inbound address outside every region gives `rx_hit` low and `rx_out_addr` zero.
- R9: A region of length zero never matches, and the next region starts where the zero-length region would have started.
- R10: `rx_out_valid` equals `rx_in_valid` from the previous cycle, and `rx_hit` is high only while `rx_out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| tx_in_valid | input | 1 | Outbound address valid |
| tx_in_addr | input | 32 | Outbound local address |
| tx_out_valid | output | 1 | Outbound address inside window, translated |
| tx_out_addr | output | 32 | Translated remote address |
| rx_in_valid | input | 1 | Inbound address valid |
| rx_in_addr | input | 32 | Inbound address from link |
| rx_out_valid | output | 1 | Inbound result valid |
| rx_hit | output | 1 | Inbound address matched a region |
| rx_out_addr | output | 32 | Local target address, zero on miss |

## Verification
All three result paths have one register stage. A read, an outbound translation and an inbound decode each appear on the outputs exactly one clock after the inputs are applied. The bench drives inputs on the falling edge and samples on the following falling edge, so each sample falls after the single capturing rising edge. A register write takes effect at the rising edge where the strobe is high. Its read-back is therefore requested one cycle later and sampled one cycle after that. Window and region edges, the zero-length region and a mid-run reset are driven as directed cases after the vector tables.

// File: rtl/addr_xlat_pkg.sv
package addr_xlat_pkg;

    localparam int AW       = 32;
    localparam int WORD_LSB = 2;

    // Fixed local window that reaches the remote side
    localparam logic [AW-1:0] WIN_BASE = 32'h4C00_0000;
    localparam int            WIN_BITS = 26;

    typedef logic [AW-1:WORD_LSB] map_word_t;

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] addr;
    } xaddr_t;

    typedef struct packed {
        logic          valid;
        logic          hit;
        logic [AW-1:0] addr;
    } rx_res_t;

    function automatic logic [AW-1:0] widen(input map_word_t w);
        return {w, {WORD_LSB{1'b0}}};
    endfunction

    function automatic logic in_window(input logic [AW-1:0] a);
        return a[AW-1:WIN_BITS] == WIN_BASE[AW-1:WIN_BITS];
    endfunction

endpackage

// File: rtl/addr_xlat_regs.sv
module addr_xlat_regs
    import addr_xlat_pkg::*;
#(
    parameter int N_REGIONS = 4,
    parameter int REG_IDX_W = $clog2(2*N_REGIONS+1)
)(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            reg_wr,
    input  logic [REG_IDX_W-1:0]            reg_addr,
    input  logic [AW-1:0]                   reg_wdata,
    output logic [AW-1:0]                   reg_rdata,
    output map_word_t                       tx_base,
    output map_word_t [N_REGIONS-1:0]       sizes,
    output map_word_t [N_REGIONS-1:0]       offs
);
    localparam int N_REG = 2*N_REGIONS + 1;

    map_word_t     regs [N_REG];
    logic          idx_ok;
    logic          unused_low;

    assign idx_ok     = int'(reg_addr) < N_REG;
    assign unused_low = ^reg_wdata[WORD_LSB-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_REG; i++) regs[i] <= '0;
            reg_rdata <= '0;
        end else begin
            if (reg_wr && idx_ok)
                regs[reg_addr] <= reg_wdata[AW-1:WORD_LSB];
            reg_rdata <= idx_ok ? widen(regs[reg_addr]) : '0;
        end
    end

    assign tx_base = regs[0];

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_pair
        assign sizes[g] = regs[1 + 2*g];
        assign offs[g]  = regs[2 + 2*g];
    end

endmodule

// File: rtl/addr_xlat_tx.sv
module addr_xlat_tx
    import addr_xlat_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_in_valid,
    input  logic [AW-1:0] tx_in_addr,
    input  map_word_t     tx_base,
    output xaddr_t        tx_out
);
    logic [AW-1:0] rebased;
    logic          take;

    assign take    = tx_in_valid && in_window(tx_in_addr);
    assign rebased = widen(tx_base) + {{(AW-WIN_BITS){1'b0}}, tx_in_addr[WIN_BITS-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_out <= '0;
        end else begin
            tx_out.valid <= take;
            tx_out.addr  <= take ? rebased : '0;
        end
    end

endmodule

// File: rtl/addr_xlat_rx.sv
module addr_xlat_rx
    import addr_xlat_pkg::*;
#(
    parameter int N_REGIONS = 4
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rx_in_valid,
    input  logic [AW-1:0]             rx_in_addr,
    input  map_word_t [N_REGIONS-1:0] sizes,
    input  map_word_t [N_REGIONS-1:0] offs,
    output rx_res_t                   rx_out
);
    // Running sum needs headroom so the sum of all lengths never wraps
    localparam int SUM_W = AW + $clog2(N_REGIONS + 1);

    logic [SUM_W-1:0]     bound [N_REGIONS+1];
    logic [N_REGIONS-1:0] match;
    logic [SUM_W-1:0]     a_ext;
    logic                 found;
    logic [AW-1:0]        sel_addr;

    assign a_ext    = {{(SUM_W-AW){1'b0}}, rx_in_addr};
    assign bound[0] = '0;

    for (genvar g = 0; g < N_REGIONS; g++) begin : g_region
        assign bound[g+1] = bound[g] + {{(SUM_W-AW){1'b0}}, widen(sizes[g])};
        assign match[g]   = (a_ext >= bound[g]) && (a_ext < bound[g+1]);
    end

    always_comb begin
        found    = 1'b0;
        sel_addr = '0;
        for (int i = N_REGIONS - 1; i >= 0; i--) begin
            if (match[i]) begin
                found    = 1'b1;
                sel_addr = rx_in_addr - bound[i][AW-1:0] + widen(offs[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_out <= '0;
        end else begin
            rx_out.valid <= rx_in_valid;
            rx_out.hit   <= rx_in_valid && found;
            rx_out.addr  <= (rx_in_valid && found) ? sel_addr : '0;
        end
    end

endmodule

// File: rtl/addr_xlat.sv
module addr_xlat
    import addr_xlat_pkg::*;
#(
    parameter int N_REGIONS = 4,
    parameter int REG_IDX_W = $clog2(2*N_REGIONS+1)
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [REG_IDX_W-1:0] reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic                 tx_in_valid,
    input  logic [31:0]          tx_in_addr,
    output logic                 tx_out_valid,
    output logic [31:0]          tx_out_addr,
    input  logic                 rx_in_valid,
    input  logic [31:0]          rx_in_addr,
    output logic                 rx_out_valid,
    output logic                 rx_hit,
    output logic [31:0]          rx_out_addr
);
    map_word_t                 tx_base;
    map_word_t [N_REGIONS-1:0] sizes;
    map_word_t [N_REGIONS-1:0] offs;
    xaddr_t                    tx_res;
    rx_res_t                   rx_res;

    addr_xlat_regs #(.N_REGIONS(N_REGIONS), .REG_IDX_W(REG_IDX_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .tx_base  (tx_base),
        .sizes    (sizes),
        .offs     (offs)
    );

    addr_xlat_tx u_tx (
        .clk        (clk),
        .rst        (rst),
        .tx_in_valid(tx_in_valid),
        .tx_in_addr (tx_in_addr),
        .tx_base    (tx_base),
        .tx_out     (tx_res)
    );

    addr_xlat_rx #(.N_REGIONS(N_REGIONS)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_in_valid(rx_in_valid),
        .rx_in_addr (rx_in_addr),
        .sizes      (sizes),
        .offs       (offs),
        .rx_out     (rx_res)
    );

    assign tx_out_valid = tx_res.valid;
    assign tx_out_addr  = tx_res.addr;
    assign rx_out_valid = rx_res.valid;
    assign rx_hit       = rx_res.hit;
    assign rx_out_addr  = rx_res.addr;

endmodule

// File: rtl/addr_xlat_chk.sv
module addr_xlat_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] reg_rdata,
    input logic        tx_in_valid,
    input logic [31:0] tx_in_addr,
    input logic        tx_out_valid,
    input logic [31:0] tx_out_addr,
    input logic        rx_in_valid,
    input logic        rx_out_valid,
    input logic        rx_hit,
    input logic [31:0] rx_out_addr
);
    // R2: low bits of every read-back are zero
    p_rdata_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[1:0] == 2'b00);

    // R4: a translated address keeps the low bits of the in-window offset
    p_tx_keep_low_r4: assert property (@(posedge clk) disable iff (rst)
        tx_out_valid |-> tx_out_addr[1:0] == $past(tx_in_addr[1:0]));

    // R5: translation only follows a valid in-window request
    p_tx_only_window_r5: assert property (@(posedge clk) disable iff (rst)
        tx_out_valid |-> ($past(tx_in_valid) &&
                          $past(tx_in_addr[31:26]) == 6'b010011));

    // R5: no request, no output
    p_tx_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !tx_in_valid |=> (!tx_out_valid && tx_out_addr == 32'h0));

    // R8: a miss leaves the address at zero
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_out_valid && !rx_hit) |-> rx_out_addr == 32'h0);

    // R10: result valid follows input valid by one cycle
    p_rx_follow_r10: assert property (@(posedge clk) disable iff (rst)
        rx_in_valid |=> rx_out_valid);

    p_rx_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !rx_in_valid |=> !rx_out_valid);

    // R10: hit implies valid
    p_hit_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
        rx_hit |-> rx_out_valid);

endmodule

bind addr_xlat addr_xlat_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_rdata   (reg_rdata),
    .tx_in_valid (tx_in_valid),
    .tx_in_addr  (tx_in_addr),
    .tx_out_valid(tx_out_valid),
    .tx_out_addr (tx_out_addr),
    .rx_in_valid (rx_in_valid),
    .rx_out_valid(rx_out_valid),
    .rx_hit      (rx_hit),
    .rx_out_addr (rx_out_addr)
);

// File: tb/tb_addr_xlat.sv
module tb_addr_xlat;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_in_valid = 1'b0;
    logic [31:0] tx_in_addr = '0;
    logic        tx_out_valid;
    logic [31:0] tx_out_addr;
    logic        rx_in_valid = 1'b0;
    logic [31:0] rx_in_addr = '0;
    logic        rx_out_valid;
    logic        rx_hit;
    logic [31:0] rx_out_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    addr_xlat dut (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_in_valid(tx_in_valid), .tx_in_addr(tx_in_addr),
        .tx_out_valid(tx_out_valid), .tx_out_addr(tx_out_addr),
        .rx_in_valid(rx_in_valid), .rx_in_addr(rx_in_addr),
        .rx_out_valid(rx_out_valid), .rx_hit(rx_hit), .rx_out_addr(rx_out_addr)
    );

    // Outbound vectors, base programmed to 1234_5000h
    localparam int NTX = 6;
    localparam logic [31:0] TX_IN  [NTX] = '{32'h4C00_0000, 32'h4FFF_FFFC, 32'h4C00_0154,
                                             32'h4BFF_FFFC, 32'h5000_0000, 32'h4E00_0003};
    localparam logic        TX_V   [NTX] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam logic [31:0] TX_OUT [NTX] = '{32'h1234_5000, 32'h1634_4FFC, 32'h1234_5154,
                                             32'h0, 32'h0, 32'h1434_5003};

    // Inbound vectors; lengths 1000h, 0, 2000h, 100h
    localparam int NRX = 8;
    localparam logic [31:0] RX_IN  [NRX] = '{32'h0000_0000, 32'h0000_0FFC, 32'h0000_1000,
                                             32'h0000_2FFC, 32'h0000_3000, 32'h0000_30FC,
                                             32'h0000_3100, 32'hFFFF_FFF0};
    localparam logic        RX_H   [NRX] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic [31:0] RX_OUT [NRX] = '{32'h8000_0000, 32'h8000_0FFC, 32'h2000_0000,
                                             32'h2000_1FFC, 32'h3000_0000, 32'h3000_00FC,
                                             32'h0, 32'h0};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = idx;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic tx(input logic [31:0] a, input logic v, input logic [31:0] exp, input string tag);
        @(negedge clk);
        tx_in_valid = 1'b1; tx_in_addr = a;
        @(negedge clk);
        chk({tag, " valid"}, {31'b0, tx_out_valid}, {31'b0, v});
        chk({tag, " addr"}, tx_out_addr, exp);
        tx_in_valid = 1'b0;
    endtask

    task automatic rx(input logic [31:0] a, input logic h, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rx_in_valid = 1'b1; rx_in_addr = a;
        @(negedge clk);
        chk({tag, " valid"}, {31'b0, rx_out_valid}, 32'h1);
        chk({tag, " hit"}, {31'b0, rx_hit}, {31'b0, h});
        chk({tag, " addr"}, rx_out_addr, exp);
        rx_in_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not end");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        for (int i = 0; i < 9; i++) rd(i[3:0], 32'h0, "R1 reset read");
        tx(32'h4C00_0010, 1'b1, 32'h0000_0010, "R1 zero base");

        // R2: low bits masked
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, 32'hFFFF_FFFC, "R2 low bits");

        // program map
        wr(4'd0, 32'h1234_5000);
        wr(4'd1, 32'h0000_1000); wr(4'd2, 32'h8000_0000);
        wr(4'd3, 32'h0000_0000); wr(4'd4, 32'h1111_0000);
        wr(4'd5, 32'h0000_2000); wr(4'd6, 32'h2000_0000);
        wr(4'd7, 32'h0000_0100); wr(4'd8, 32'h3000_0000);
        rd(4'd0, 32'h1234_5000, "R2 base readback");
        rd(4'd8, 32'h3000_0000, "R2 offset readback");

        // R3: unmapped indices
        wr(4'd9, 32'hDEAD_BEEC);
        wr(4'd15, 32'hDEAD_BEEC);
        rd(4'd9, 32'h0, "R3 unmapped read");
        rd(4'd15, 32'h0, "R3 unmapped read");
        rd(4'd0, 32'h1234_5000, "R3 base untouched");
        rd(4'd1, 32'h0000_1000, "R3 size untouched");

        // R4 / R5 outbound table
        for (int i = 0; i < NTX; i++)
            tx(TX_IN[i], TX_V[i], TX_OUT[i], TX_V[i] ? "R4 tx vector" : "R5 tx vector");

        // R6 / R7 / R8 / R9 inbound table
        for (int i = 0; i < NRX; i++)
            rx(RX_IN[i], RX_H[i], RX_OUT[i], RX_H[i] ? "R6 R7 R9 rx vector" : "R8 rx vector");

        // R5: idle outbound cycle
        @(negedge clk);
        chk("R5 idle valid", {31'b0, tx_out_valid}, 32'h0);

        // R10: no inbound valid, no result
        @(negedge clk);
        rx_in_addr = 32'h0000_0000;
        @(negedge clk);
        chk("R10 idle valid", {31'b0, rx_out_valid}, 32'h0);
        chk("R10 idle hit", {31'b0, rx_hit}, 32'h0);

        // R4: wrap modulo 2^32
        wr(4'd0, 32'hFFFF_FFFC);
        tx(32'h4C00_0008, 1'b1, 32'h0000_0004, "R4 wrap");

        // R9: all lengths zero -> nothing matches
        wr(4'd1, 32'h0); wr(4'd5, 32'h0); wr(4'd7, 32'h0);
        rx(32'h0000_0000, 1'b0, 32'h0, "R9 all zero");

        // R1: reset mid-run clears map
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        rd(4'd0, 32'h0, "R1 after reset");
        rd(4'd2, 32'h0, "R1 after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule